// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

The controller gathers level-sensitive interrupt requests from two banks of sixteen peripheral sources and steers each one onto one of five processor interrupt lines. Every source passes through a per-bank mask. A source counts as active only when its input is high and its mask bit is set. A subset of sources carries a three-bit routing code held in one of four shared routing registers. The remaining sources always go to line 0.

Software reaches the mask and routing registers through a simple 16-bit register bus with address, write enable and registered read data. When the processor services a line, it issues a query naming that line. One cycle later the block answers with the winning source, as a bank number and pin index, or it raises a spurious flag when nothing active is routed there.

Top module: `irq_route_ctrl`

## Requirements
- R1: After a synchronous reset both mask registers read 0 and `cpu_int` is 0. Routing register A reads 0x0040 (bank 0 pin 2 goes to line 1). Routing register C reads 0x0002 (bank 1 pin 0 goes to line 2). Routing registers B and D read 0.
- R2: The pending register of each bank reads the input levels sampled one clock earlier. Nothing latches them. Bus writes to a pending register have no effect.
- R3: A source is active when its sampled level and its mask bit are both 1. Bit L of `cpu_int` is 1 exactly when some active source is routed to line L. The line follows an input change two clocks later.
- R4: Routing code values 0 to 4 select lines 0 to 4. A written field whose value is 5, 6 or 7 is rejected, and that field keeps its old value. Other fields written by the same access still update.
- R5: The routing field layout (bit offset of each 3-bit field) is as follows. Register A holds bank 0 pins 0,1,2,3,8 at offsets 0,3,6,9,12. Register B holds bank 0 pins 9,11,12 at offsets 0,6,9. Register C holds bank 1 pins 0,1,3,4,5 at offsets 0,3,6,9,12. Register D holds bank 1 pins 6,7,8,9,10 at offsets 0,3,6,9,12.
- R6: Sources with no routing field always drive line 0. Routing register bits that hold no field read as 0.
- R7: When `qry_valid` is asserted, `id_valid` is 1 on the next cycle. `id_bank` (0 = first bank) and `id_pin` then name the lowest-indexed active source routed to `qry_line`. Every first-bank source outranks every second-bank source.
- R8: A query sets `id_spurious` (with `id_bank` and `id_pin` at 0) when no active source is routed to the queried line, or when `qry_line` is 5 or above.
- R9: `bus_addr[5]` selects the window and `bus_addr[4:0]` is the byte offset. Window 0 holds: pending 0x00, routing A 0x04, routing B 0x06, mask 0x0C, routing C 0x1C, routing D 0x1E. Window 1 holds: pending 0x00, mask 0x06. Read data appears on the cycle after the address. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl0 | input | 16 | Request levels of the first bank |
| src_lvl1 | input | 16 | Request levels of the second bank |
| bus_addr | input | 6 | Window select and byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cpu_int | output | 5 | Processor interrupt lines |
| qry_valid | input | 1 | Source identification request |
| qry_line | input | 3 | Line being identified |
| id_valid | output | 1 | Identification result valid |
| id_bank | output | 1 | Bank of the identified source |
| id_pin | output | 4 | Pin index of the identified source |
| id_spurious | output | 1 | No active source on the queried line |

## Verification
The hardest state to reach is a mixed routing register write. In that write some fields carry legal codes and others illegal ones, and it lands while several active sources in both banks compete for one line. Only the per-field rejection then decides which source wins the query. The stimulus gets there with randomly generated routing words, levels and masks, so illegal codes appear in about three fields of eight. After each step, every line is queried and compared with a bench model that applies the field rule on its own. Directed sweeps add single-source walks under each uniform code, and cross-bank priority ties.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NPIN = 16;
  localparam int NOUT = 5;
  localparam int CW   = 3;
  localparam int DW   = 16;
  localparam int NASG = 4;
  localparam int NFLD = 18;
  localparam int AW   = 6;
  localparam logic [CW-1:0] CODE_MAX = 3'd4;

  localparam logic [4:0] OFF_PEND  = 5'h00;
  localparam logic [4:0] OFF_ASG_A = 5'h04;
  localparam logic [4:0] OFF_ASG_B = 5'h06;
  localparam logic [4:0] OFF_MASK0 = 5'h0C;
  localparam logic [4:0] OFF_ASG_C = 5'h1C;
  localparam logic [4:0] OFF_ASG_D = 5'h1E;
  localparam logic [4:0] OFF_MASK1 = 5'h06;

  // routing register holding field i
  function automatic int fld_reg(int i);
    if (i < 5)  return 0;
    if (i < 8)  return 1;
    if (i < 13) return 2;
    return 3;
  endfunction

  function automatic int fld_off(int i);
    if (i < 5)  return i * 3;
    if (i == 5) return 0;
    if (i == 6) return 6;
    if (i == 7) return 9;
    if (i < 13) return (i - 8) * 3;
    return (i - 13) * 3;
  endfunction

  function automatic int fld_bank(int i);
    return (i < 8) ? 0 : 1;
  endfunction

  function automatic int fld_pin(int i);
    case (i)
      4:  return 8;
      5:  return 9;
      6:  return 11;
      7:  return 12;
      8:  return 0;
      9:  return 1;
      10: return 3;
      11: return 4;
      12: return 5;
      default: return (i < 4) ? i : i - 7;
    endcase
  endfunction

  function automatic logic [CW-1:0] fld_rst(int i);
    if (i == 2) return 3'd1;
    if (i == 8) return 3'd2;
    return 3'd0;
  endfunction

  // field index serving flat source s, or -1
  function automatic int src_fld(int s, int npin);
    for (int i = 0; i < NFLD; i++)
      if (fld_bank(i) * npin + fld_pin(i) == s) return i;
    return -1;
  endfunction
endpackage

// File: rtl/irq_asg_regs.sv
module irq_asg_regs
  import irq_route_pkg::*;
#(
  parameter int NF = NFLD,
  parameter int FW = CW,
  parameter int RW = DW,
  parameter int NR = NASG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NR-1:0]    wr_sel,
  input  logic [RW-1:0]    wr_data,
  output logic [NF*FW-1:0] fld_o,
  output logic [NR*RW-1:0] rdback
);
  localparam int TOT = NR * RW;

  logic [FW-1:0]  fld_q   [NF];
  logic [TOT-1:0] fld_vec [NF];

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam int R   = fld_reg(i);
    localparam int OFF = fld_off(i);
    logic [FW-1:0] nv;
    assign nv = wr_data[OFF +: FW];
    always_ff @(posedge clk) begin
      if (rst) fld_q[i] <= fld_rst(i);
      else if (wr_en && wr_sel[R] && (nv <= CODE_MAX)) fld_q[i] <= nv;
    end
    assign fld_o[i*FW +: FW] = fld_q[i];
    assign fld_vec[i] = TOT'(fld_q[i]) << (R * RW + OFF);
  end

  always_comb begin
    rdback = '0;
    for (int i = 0; i < NF; i++) rdback = rdback | fld_vec[i];
  end
endmodule

// File: rtl/irq_line_find.sv
module irq_line_find #(
  parameter int NSRC = 32,
  parameter int IW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] hits,
  output logic            found,
  output logic [IW-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (hits[k]) idx = IW'(k);
  end
  assign found = |hits;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NP = NPIN,
  parameter int NL = NOUT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NP-1:0]     src_lvl0,
  input  logic [NP-1:0]     src_lvl1,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NL-1:0]     cpu_int,
  input  logic              qry_valid,
  input  logic [2:0]        qry_line,
  output logic              id_valid,
  output logic              id_bank,
  output logic [$clog2(NP)-1:0] id_pin,
  output logic              id_spurious
);
  localparam int NSRC = 2 * NP;
  localparam int SW   = $clog2(NSRC);
  localparam int PW   = $clog2(NP);

  logic [NSRC-1:0]         pend_q;
  logic [NP-1:0]           mask0_q, mask1_q;
  logic [NSRC-1:0]         mask_all, active;
  logic [NSRC-1:0][CW-1:0] pin_code;
  logic [NFLD*CW-1:0]      fld;
  logic [NASG*DW-1:0]      asg_rd;
  logic [NASG-1:0]         asg_sel;
  logic [NL-1:0]           line_found;
  logic [SW-1:0]           line_idx [NL];
  logic                    win;
  logic [4:0]              off;
  logic                    sel_found;
  logic [SW-1:0]           sel_idx;
  logic [DW-1:0]           rd_next;

  assign win = bus_addr[AW-1];
  assign off = bus_addr[4:0];

  // level sampling, no latching
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= {src_lvl1, src_lvl0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask0_q <= '0;
      mask1_q <= '0;
    end else if (bus_we) begin
      if (!win && off == OFF_MASK0) mask0_q <= bus_wdata[NP-1:0];
      if ( win && off == OFF_MASK1) mask1_q <= bus_wdata[NP-1:0];
    end
  end

  always_comb begin
    asg_sel = '0;
    if (!win) begin
      asg_sel[0] = (off == OFF_ASG_A);
      asg_sel[1] = (off == OFF_ASG_B);
      asg_sel[2] = (off == OFF_ASG_C);
      asg_sel[3] = (off == OFF_ASG_D);
    end
  end

  irq_asg_regs u_asg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_we),
    .wr_sel  (asg_sel),
    .wr_data (bus_wdata),
    .fld_o   (fld),
    .rdback  (asg_rd)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int F = src_fld(s, NP);
    if (F >= 0) begin : g_routed
      assign pin_code[s] = fld[F*CW +: CW];
    end else begin : g_fixed
      assign pin_code[s] = '0;
    end
  end

  assign mask_all = {mask1_q, mask0_q};
  assign active   = pend_q & mask_all;

  for (genvar l = 0; l < NL; l++) begin : g_line
    logic [NSRC-1:0] hits;
    for (genvar s = 0; s < NSRC; s++) begin : g_hit
      assign hits[s] = active[s] && (pin_code[s] == CW'(l));
    end
    irq_line_find #(.NSRC(NSRC), .IW(SW)) u_find (
      .hits  (hits),
      .found (line_found[l]),
      .idx   (line_idx[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_int <= '0;
    else     cpu_int <= line_found;
  end

  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int l = 0; l < NL; l++) begin
      if (qry_line == 3'(l)) begin
        sel_found = line_found[l];
        sel_idx   = line_idx[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_valid    <= 1'b0;
      id_bank     <= 1'b0;
      id_pin      <= '0;
      id_spurious <= 1'b0;
    end else begin
      id_valid    <= qry_valid;
      id_spurious <= qry_valid && !sel_found;
      id_bank     <= (qry_valid && sel_found) ? sel_idx[SW-1] : 1'b0;
      id_pin      <= (qry_valid && sel_found) ? sel_idx[PW-1:0] : '0;
    end
  end

  always_comb begin
    rd_next = '0;
    if (!win) begin
      case (off)
        OFF_PEND:  rd_next = DW'(pend_q[NP-1:0]);
        OFF_MASK0: rd_next = DW'(mask0_q);
        OFF_ASG_A: rd_next = asg_rd[0*DW +: DW];
        OFF_ASG_B: rd_next = asg_rd[1*DW +: DW];
        OFF_ASG_C: rd_next = asg_rd[2*DW +: DW];
        OFF_ASG_D: rd_next = asg_rd[3*DW +: DW];
        default:   rd_next = '0;
      endcase
    end else begin
      case (off)
        OFF_PEND:  rd_next = DW'(pend_q[NSRC-1:NP]);
        OFF_MASK1: rd_next = DW'(mask1_q);
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NSRC = 32,
  parameter int NL   = 5,
  parameter int CW   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NL-1:0]    cpu_int,
  input logic             qry_valid,
  input logic             id_valid,
  input logic             id_spurious,
  input logic [NSRC-1:0]  mask_all,
  input logic [NSRC-1:0]  active,
  input logic [NSRC*CW-1:0] pin_code
);
  logic all_legal;
  always_comb begin
    all_legal = 1'b1;
    for (int s = 0; s < NSRC; s++)
      if (pin_code[s*CW +: CW] > CW'(NL - 1)) all_legal = 1'b0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> cpu_int == '0); // R1
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst) (mask_all == '0) |=> cpu_int == '0); // R3
  AST_INT_HAS_SRC: assert property (@(posedge clk) disable iff (rst) (cpu_int != '0) |-> $past(active != '0)); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) all_legal); // R4
  AST_QUERY_ANSWER: assert property (@(posedge clk) disable iff (rst) qry_valid |=> id_valid); // R7
  AST_SPUR_VALID: assert property (@(posedge clk) disable iff (rst) id_spurious |-> id_valid); // R8
endmodule

bind irq_route_ctrl irq_route_chk #(.NSRC(NSRC), .NL(NL), .CW(irq_route_pkg::CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_int     (cpu_int),
  .qry_valid   (qry_valid),
  .id_valid    (id_valid),
  .id_spurious (id_spurious),
  .mask_all    (mask_all),
  .active      (active),
  .pin_code    (pin_code)
);

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_lvl0 = '0, src_lvl1 = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  cpu_int;
  logic        qry_valid = 1'b0;
  logic [2:0]  qry_line = '0;
  logic        id_valid, id_bank, id_spurious;
  logic [3:0]  id_pin;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m0, m1;
  logic [15:0] asg [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_ctrl dut (
    .clk(clk), .rst(rst), .src_lvl0(src_lvl0), .src_lvl1(src_lvl1),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_int(cpu_int), .qry_valid(qry_valid), .qry_line(qry_line),
    .id_valid(id_valid), .id_bank(id_bank), .id_pin(id_pin), .id_spurious(id_spurious)
  );

  localparam logic [5:0] A_PEND0 = 6'h00, A_ASGA = 6'h04, A_ASGB = 6'h06, A_MASK0 = 6'h0C,
                         A_ASGC = 6'h1C, A_ASGD = 6'h1E, A_PEND1 = 6'h20, A_MASK1 = 6'h26;

  function automatic logic [5:0] asg_addr(int r);
    case (r)
      0: return A_ASGA;
      1: return A_ASGB;
      2: return A_ASGC;
      default: return A_ASGD;
    endcase
  endfunction

  function automatic bit slot_used(int r, int o);
    if (r == 1) return (o == 0 || o == 6 || o == 9);
    return 1'b1;
  endfunction

  function automatic logic [2:0] model_code(int b, int p);
    if (b == 0) begin
      if (p <= 3)  return asg[0][p*3 +: 3];
      if (p == 8)  return asg[0][12 +: 3];
      if (p == 9)  return asg[1][0 +: 3];
      if (p == 11) return asg[1][6 +: 3];
      if (p == 12) return asg[1][9 +: 3];
      return 3'd0;
    end
    if (p <= 1) return asg[2][p*3 +: 3];
    if (p >= 3 && p <= 5) return asg[2][(p-1)*3 +: 3];
    if (p >= 6 && p <= 10) return asg[3][(p-6)*3 +: 3];
    return 3'd0;
  endfunction

  function automatic bit is_act(int b, int p);
    return (b == 0) ? (src_lvl0[p] & m0[p]) : (src_lvl1[p] & m1[p]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    if (a == A_MASK0) m0 = d;
    if (a == A_MASK1) m1 = d;
    for (int r = 0; r < 4; r++)
      if (a == asg_addr(r))
        for (int o = 0; o <= 12; o += 3)
          if (slot_used(r, o) && d[o +: 3] <= 3'd4) asg[r][o +: 3] = d[o +: 3];
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // full comparison of all lines and queries against the model
  task automatic verify_all(string tag);
    logic [4:0] e_int;
    settle();
    e_int = '0;
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 16; p++)
        if (is_act(b, p)) e_int[model_code(b, p)] = 1'b1;
    chk({"R3 cpu_int ", tag}, 32'(cpu_int), 32'(e_int));
    for (int l = 0; l < 8; l++) begin
      bit fnd; int eb, ep;
      fnd = 0; eb = 0; ep = 0;
      for (int s = 0; s < 32 && !fnd; s++)
        if (l < 5 && is_act(s / 16, s % 16) && model_code(s / 16, s % 16) == 3'(l)) begin
          fnd = 1; eb = s / 16; ep = s % 16;
        end
      @(negedge clk);
      qry_valid = 1'b1; qry_line = 3'(l);
      @(posedge clk);
      @(negedge clk);
      qry_valid = 1'b0;
      chk({"R7 id_valid ", tag}, 32'(id_valid), 32'd1);
      chk({"R8 id_spurious ", tag}, 32'(id_spurious), 32'(!fnd));
      chk({"R7 id_bank/pin ", tag}, {27'd0, id_bank, id_pin}, 32'(eb * 16 + ep));
    end
  endtask

  task automatic verify_regs(string tag);
    logic [15:0] d;
    rd(A_MASK0, d); chk({"R9 mask0 ", tag}, 32'(d), 32'(m0));
    rd(A_MASK1, d); chk({"R9 mask1 ", tag}, 32'(d), 32'(m1));
    for (int r = 0; r < 4; r++) begin
      rd(asg_addr(r), d);
      chk({"R5 routing readback ", tag}, 32'(d), 32'(asg[r]));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    m0 = '0; m1 = '0;
    asg[0] = 16'h0040; asg[1] = '0; asg[2] = 16'h0002; asg[3] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset values
    chk("R1 cpu_int after reset", 32'(cpu_int), 32'd0);
    rd(A_ASGA, d); chk("R1 routing A default", 32'(d), 32'h0040);
    rd(A_ASGB, d); chk("R1 routing B default", 32'(d), 32'h0000);
    rd(A_ASGC, d); chk("R1 routing C default", 32'(d), 32'h0002);
    rd(A_ASGD, d); chk("R1 routing D default", 32'(d), 32'h0000);
    rd(A_MASK0, d); chk("R1 mask0 default", 32'(d), 32'h0);
    rd(A_MASK1, d); chk("R1 mask1 default", 32'(d), 32'h0);

    // R2 level sampling; R3 masks closed means no lines
    @(negedge clk); src_lvl0 = 16'hA5A5; src_lvl1 = 16'h5A5A;
    verify_all("masked");
    rd(A_PEND0, d); chk("R2 pending0 level", 32'(d), 32'hA5A5);
    rd(A_PEND1, d); chk("R2 pending1 level", 32'(d), 32'h5A5A);
    wr(A_PEND0, 16'h0000); wr(A_PEND1, 16'hFFFF);
    rd(A_PEND0, d); chk("R2 pending0 write ignored", 32'(d), 32'hA5A5);
    rd(A_PEND1, d); chk("R2 pending1 write ignored", 32'(d), 32'h5A5A);
    @(negedge clk); src_lvl0 = '0; src_lvl1 = '0;
    settle();
    rd(A_PEND0, d); chk("R2 pending0 follows drop", 32'(d), 32'h0);

    // R9 unmapped offsets
    rd(6'h02, d); chk("R9 unmapped window0", 32'(d), 32'h0);
    rd(6'h2C, d); chk("R9 unmapped window1", 32'(d), 32'h0);

    // single-source walk under default routing (R3, R5, R7)
    wr(A_MASK0, 16'hFFFF); wr(A_MASK1, 16'hFFFF);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      src_lvl0 = (s < 16) ? 16'(1 << s) : '0;
      src_lvl1 = (s >= 16) ? 16'(1 << (s - 16)) : '0;
      verify_all("default walk");
    end

    // uniform codes on every field, then walk (R4, R5, R6)
    for (int c = 0; c < 5; c++) begin
      logic [15:0] w;
      w = '0;
      for (int o = 0; o <= 12; o += 3) w[o +: 3] = 3'(c);
      for (int r = 0; r < 4; r++) wr(asg_addr(r), w);
      verify_regs("uniform");
      rd(A_ASGB, d); chk("R6 unused slot reads zero", 32'(d[5:3]), 32'd0);
      for (int s = 0; s < 32; s++) begin
        @(negedge clk);
        src_lvl0 = (s < 16) ? 16'(1 << s) : '0;
        src_lvl1 = (s >= 16) ? 16'(1 << (s - 16)) : '0;
        verify_all("uniform walk R6");
      end
    end

    // R4 illegal codes rejected per field
    wr(A_ASGA, 16'h1234 & 16'h7FFF);
    wr(A_ASGA, 16'hFFFF);
    verify_regs("all illegal R4");
    wr(A_ASGA, {1'b0, 3'd6, 3'd2, 3'd7, 3'd3, 3'd5});
    verify_regs("mixed R4");

    // R7 cross-bank priority: bank0 pin 5 (fixed line 0) beats bank1 pin 0
    wr(A_ASGC, 16'h0000);
    @(negedge clk); src_lvl0 = 16'h0020; src_lvl1 = 16'h0001;
    verify_all("priority R7");
    @(negedge clk); src_lvl0 = 16'h0000;
    verify_all("bank1 only R7");
    wr(A_MASK1, 16'h0000);
    verify_all("spurious R8");

    // random sweep
    for (int it = 0; it < 150; it++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[0]) wr(A_MASK0, 16'($urandom));
      if (rv[1]) wr(A_MASK1, 16'($urandom));
      if (rv[2]) wr(asg_addr(int'(rv[5:4])), 16'($urandom));
      if (rv[3]) wr(asg_addr(int'(rv[7:6])), 16'($urandom));
      @(negedge clk); src_lvl0 = 16'($urandom); src_lvl1 = 16'($urandom);
      verify_all("random");
      if (rv[8]) verify_regs("random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule